// File: doc/BRIEF.md
# Type B Card-Side Command Responder

This block serves the card-emulation end of a proximity Type B link. Received frames reach it as a byte stream framed by a start strobe and an end strobe. Once a frame closes, the block sorts it into one of three classes: identification probe, halt/attribute command, or unknown. It then either streams a fixed reply frame out through a valid/ready byte port or stays silent. After a silent frame it is ready to listen again at once.

The two probe commands, wake-up and request, are recognised only when every byte matches. Halt and attribute commands are recognised from the frame length and the opcode byte alone. An unknown frame of at least three bytes has its trailing two-byte check value verified, and the verdict is shown on status outputs. A saturating counter records every completed frame. Modulation, demodulation and line coding are handled elsewhere.

Top module: `tagb_responder`

## Requirements
- R1: A 5-byte frame equal to 05 00 08 39 73 (wake-up) is answered with the 14-byte identification reply 50 82 0D E1 74 20 38 19 22 00 21 85 5E D7.
- R2: A 5-byte frame equal to 05 00 00 71 FF (request) is answered with the same 14-byte identification reply.
- R3: A 5-byte frame whose first byte is 0x50 (halt) is answered with the 3-byte reply 00 78 F0. The other four bytes are not examined.
- R4: An 11-byte frame whose first byte is 0x1D (attribute) is answered with 00 78 F0. The other ten bytes are not examined.
- R5: Every other frame, including a probe frame with a single wrong bit or an opcode frame of the wrong length, gets no reply. txValid stays low and the next frame is accepted normally.
- R6: For a frame without a reply, of 3 to MAX_LEN bytes, crcChecked is set. crcPass is set when the last two bytes equal the complemented reflected CRC (polynomial 0x8408, preset 0xFFFF) of all earlier bytes, with the low byte first. For answered frames and frames shorter than 3 bytes, both flags stay 0. The flags become valid in the second cycle after the end strobe and are cleared by the next start strobe.
- R7: A frame of more than MAX_LEN (64) bytes sets overLen. It is never answered and its CRC is not checked.
- R8: cmdCount starts at 0 and rises by one at each end strobe that closes an open frame. It holds at all ones.
- R9: txValid first rises in the second cycle after the end strobe. Each byte is held stable until txReady accepts it, and txLast marks the final byte.
- R10: While a frame is being judged or a reply is being sent, start strobes, end strobes and data bytes are ignored. They do not count and do not alter the reply.
- R11: A byte valid in the same cycle as the start strobe is the first byte of the frame, and a byte valid with the end strobe is its last byte. A start strobe inside an open frame drops that frame without counting it.
- R12: After reset, txValid, crcChecked, crcPass, overLen and cmdCount are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| rxStart | input | 1 | Frame start strobe |
| rxEnd | input | 1 | Frame end strobe |
| rxValid | input | 1 | Received byte valid |
| rxData | input | 8 | Received byte |
| txValid | output | 1 | Reply byte valid |
| txData | output | 8 | Reply byte |
| txLast | output | 1 | Final reply byte |
| txReady | input | 1 | Downstream accepts reply byte |
| cmdCount | output | CNT_W | Saturating count of completed frames |
| crcChecked | output | 1 | Unknown frame had its check value tested |
| crcPass | output | 1 | Tested check value matched |
| overLen | output | 1 | Last frame exceeded MAX_LEN bytes |

## Verification
Two events can share a cycle. A data byte can arrive in the same cycle as the start strobe or the end strobe, and a reply can be in flight while new receive strobes arrive. The bench drives both orderings for each of these: a byte together with a strobe, and a byte alone followed by a separate strobe. It also drives start, end and data strobes on every cycle of a reply while stalling txReady in a fixed pattern. Correctness is judged by the reply bytes received, the counter value and the status flags. These are compared with a model that counts only closed frames and classifies frames from their length and contents.

// File: rtl/tagb_pkg.sv
package tagb_pkg;

  typedef enum logic [1:0] {
    RPL_NONE  = 2'd0,
    RPL_IDENT = 2'd1,
    RPL_ACK   = 2'd2
  } rpl_e;

  typedef struct packed {
    logic clear;
    logic capture;
    logic judge;
    logic txStep;
  } ctl_s;

  localparam int IDENT_LEN = 14;
  localparam int ACK_LEN   = 3;
  localparam int PROBE_LEN = 5;
  localparam int ATTR_LEN  = 11;
  localparam logic [7:0] HALT_OP = 8'h50;
  localparam logic [7:0] ATTR_OP = 8'h1D;

  function automatic logic [7:0] identByte(input logic [3:0] i);
    case (i)
      4'd0:  return 8'h50;
      4'd1:  return 8'h82;
      4'd2:  return 8'h0D;
      4'd3:  return 8'hE1;
      4'd4:  return 8'h74;
      4'd5:  return 8'h20;
      4'd6:  return 8'h38;
      4'd7:  return 8'h19;
      4'd8:  return 8'h22;
      4'd9:  return 8'h00;
      4'd10: return 8'h21;
      4'd11: return 8'h85;
      4'd12: return 8'h5E;
      4'd13: return 8'hD7;
      default: return 8'h00;
    endcase
  endfunction

  function automatic logic [7:0] ackByte(input logic [1:0] i);
    case (i)
      2'd1:    return 8'h78;
      2'd2:    return 8'hF0;
      default: return 8'h00;
    endcase
  endfunction

  function automatic logic [7:0] wakeByte(input logic [2:0] i);
    case (i)
      3'd0:    return 8'h05;
      3'd1:    return 8'h00;
      3'd2:    return 8'h08;
      3'd3:    return 8'h39;
      default: return 8'h73;
    endcase
  endfunction

  function automatic logic [7:0] reqByte(input logic [2:0] i);
    case (i)
      3'd0:    return 8'h05;
      3'd1:    return 8'h00;
      3'd2:    return 8'h00;
      3'd3:    return 8'h71;
      default: return 8'hFF;
    endcase
  endfunction

  function automatic logic [15:0] crcStep(input logic [15:0] c, input logic [7:0] d);
    logic [15:0] r;
    r = c ^ {8'h00, d};
    for (int k = 0; k < 8; k++) begin
      r = r[0] ? ((r >> 1) ^ 16'h8408) : (r >> 1);
    end
    return r;
  endfunction

endpackage

// File: rtl/tagb_datapath.sv
module tagb_datapath
  import tagb_pkg::*;
#(
  parameter int MAX_LEN = 64
) (
  input  logic       clk,
  input  logic       rstN,
  input  ctl_s       ctl,
  input  logic [7:0] rxData,
  output rpl_e       kindNow,
  output logic [7:0] txData,
  output logic       txLast,
  output logic       crcChecked,
  output logic       crcPass,
  output logic       overLen
);

  localparam int LEN_W = $clog2(MAX_LEN + 2);
  localparam int IDX_W = $clog2(IDENT_LEN);
  localparam logic [LEN_W-1:0] L_CAP   = LEN_W'(MAX_LEN + 1);
  localparam logic [LEN_W-1:0] L_MAX   = LEN_W'(MAX_LEN);
  localparam logic [LEN_W-1:0] L_PROBE = LEN_W'(PROBE_LEN);
  localparam logic [LEN_W-1:0] L_ATTR  = LEN_W'(ATTR_LEN);
  localparam logic [LEN_W-1:0] L_TWO   = LEN_W'(2);
  localparam logic [LEN_W-1:0] L_THREE = LEN_W'(3);
  localparam logic [IDX_W-1:0] I_IDENT_END = IDX_W'(IDENT_LEN - 1);
  localparam logic [IDX_W-1:0] I_ACK_END   = IDX_W'(ACK_LEN - 1);

  logic [LEN_W-1:0] len, baseLen, nLen;
  logic [7:0]       firstByte, nFirst;
  logic             wakeHit, reqHit, baseWake, baseReq, nWake, nReq;
  logic [15:0]      crcAcc, baseCrc, nCrc;
  logic [7:0]       hist0, hist1, nH0, nH1;
  logic [IDX_W-1:0] txIdx;
  rpl_e             kindQ;
  logic             lenOver;
  logic             crcWanted;

  // next frame state, seen over a cleared frame when start and byte coincide
  always_comb begin
    baseLen  = ctl.clear ? '0 : len;
    baseWake = ctl.clear | wakeHit;
    baseReq  = ctl.clear | reqHit;
    baseCrc  = ctl.clear ? 16'hFFFF : crcAcc;
    nLen     = baseLen;
    nFirst   = firstByte;
    nWake    = baseWake;
    nReq     = baseReq;
    nCrc     = baseCrc;
    nH0      = hist0;
    nH1      = hist1;
    if (ctl.capture && baseLen != L_CAP) begin
      nLen = baseLen + 1'b1;
      if (baseLen == '0) nFirst = rxData;
      if (baseLen < L_PROBE) begin
        nWake = baseWake && (rxData == wakeByte(3'(baseLen)));
        nReq  = baseReq && (rxData == reqByte(3'(baseLen)));
      end
      // the byte two places back is now known not to be part of the check value
      if (baseLen >= L_TWO) nCrc = crcStep(baseCrc, hist0);
      nH0 = hist1;
      nH1 = rxData;
    end
  end

  always_comb begin
    lenOver = len > L_MAX;
    if (!lenOver && len == L_PROBE && (wakeHit || reqHit))
      kindNow = RPL_IDENT;
    else if (!lenOver && len == L_PROBE && firstByte == HALT_OP)
      kindNow = RPL_ACK;
    else if (!lenOver && len == L_ATTR && firstByte == ATTR_OP)
      kindNow = RPL_ACK;
    else
      kindNow = RPL_NONE;
    crcWanted = (kindNow == RPL_NONE) && !lenOver && (len >= L_THREE);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      len        <= '0;
      firstByte  <= '0;
      wakeHit    <= 1'b1;
      reqHit     <= 1'b1;
      crcAcc     <= 16'hFFFF;
      hist0      <= '0;
      hist1      <= '0;
      txIdx      <= '0;
      kindQ      <= RPL_NONE;
      crcChecked <= 1'b0;
      crcPass    <= 1'b0;
      overLen    <= 1'b0;
    end else begin
      len       <= nLen;
      firstByte <= nFirst;
      wakeHit   <= nWake;
      reqHit    <= nReq;
      crcAcc    <= nCrc;
      hist0     <= nH0;
      hist1     <= nH1;
      if (ctl.clear) begin
        crcChecked <= 1'b0;
        crcPass    <= 1'b0;
        overLen    <= 1'b0;
      end
      if (ctl.judge) begin
        kindQ      <= kindNow;
        txIdx      <= '0;
        overLen    <= lenOver;
        crcChecked <= crcWanted;
        crcPass    <= crcWanted && ((~crcAcc) == {hist1, hist0});
      end else if (ctl.txStep) begin
        txIdx <= txIdx + 1'b1;
      end
    end
  end

  always_comb begin
    if (kindQ == RPL_ACK) begin
      txData = ackByte(txIdx[1:0]);
      txLast = txIdx == I_ACK_END;
    end else begin
      txData = identByte(4'(txIdx));
      txLast = txIdx == I_IDENT_END;
    end
  end

endmodule

// File: rtl/tagb_control.sv
module tagb_control
  import tagb_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             rxStart,
  input  logic             rxEnd,
  input  logic             rxValid,
  input  rpl_e             kindNow,
  input  logic             txReady,
  input  logic             txLast,
  output ctl_s             ctl,
  output logic             txValid,
  output logic [CNT_W-1:0] cmdCount
);

  typedef enum logic [1:0] {ST_LISTEN, ST_COLLECT, ST_DECIDE, ST_SEND} st_e;

  st_e  st, stNext;
  logic frameDone;
  logic open;

  always_comb begin
    open        = (st == ST_LISTEN) || (st == ST_COLLECT);
    ctl.clear   = open && rxStart;
    ctl.capture = rxValid && (ctl.clear || st == ST_COLLECT);
    ctl.judge   = st == ST_DECIDE;
    ctl.txStep  = (st == ST_SEND) && txReady;
    frameDone   = (st == ST_COLLECT) && rxEnd && !rxStart;
    txValid     = st == ST_SEND;
  end

  always_comb begin
    stNext = st;
    case (st)
      ST_LISTEN:  if (rxStart) stNext = ST_COLLECT;
      ST_COLLECT: if (frameDone) stNext = ST_DECIDE;
      ST_DECIDE:  stNext = (kindNow == RPL_NONE) ? ST_LISTEN : ST_SEND;
      ST_SEND:    if (txReady && txLast) stNext = ST_LISTEN;
      default:    stNext = ST_LISTEN;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      st       <= ST_LISTEN;
      cmdCount <= '0;
    end else begin
      st <= stNext;
      if (frameDone && !(&cmdCount)) cmdCount <= cmdCount + 1'b1;
    end
  end

endmodule

// File: rtl/tagb_responder.sv
module tagb_responder
  import tagb_pkg::*;
#(
  parameter int MAX_LEN = 64,
  parameter int CNT_W   = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             rxStart,
  input  logic             rxEnd,
  input  logic             rxValid,
  input  logic [7:0]       rxData,
  output logic             txValid,
  output logic [7:0]       txData,
  output logic             txLast,
  input  logic             txReady,
  output logic [CNT_W-1:0] cmdCount,
  output logic             crcChecked,
  output logic             crcPass,
  output logic             overLen
);

  ctl_s ctl;
  rpl_e kindNow;

  tagb_control #(.CNT_W(CNT_W)) u_ctl (
    .clk(clk), .rstN(rstN),
    .rxStart(rxStart), .rxEnd(rxEnd), .rxValid(rxValid),
    .kindNow(kindNow), .txReady(txReady), .txLast(txLast),
    .ctl(ctl), .txValid(txValid), .cmdCount(cmdCount)
  );

  tagb_datapath #(.MAX_LEN(MAX_LEN)) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .rxData(rxData),
    .kindNow(kindNow), .txData(txData), .txLast(txLast),
    .crcChecked(crcChecked), .crcPass(crcPass), .overLen(overLen)
  );

endmodule

// File: rtl/tagb_checker.sv
module tagb_checker #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rstN,
  input logic             txValid,
  input logic             txReady,
  input logic [7:0]       txData,
  input logic             txLast,
  input logic [CNT_W-1:0] cmdCount,
  input logic             crcChecked,
  input logic             crcPass,
  input logic             overLen
);

  a_r9_hold: assert property (@(posedge clk) disable iff (!rstN)
    (txValid && !txReady) |=> (txValid && $stable(txData) && $stable(txLast)));

  a_r9_last_in_frame: assert property (@(posedge clk) disable iff (!rstN)
    (txValid && txReady && !txLast) |=> txValid);

  a_r8_step: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> (cmdCount == $past(cmdCount)) || (cmdCount == CNT_W'($past(cmdCount) + 1'b1)));

  a_r8_saturate: assert property (@(posedge clk) disable iff (!rstN)
    (&cmdCount) |=> (&cmdCount));

  a_r6_pass_needs_check: assert property (@(posedge clk) disable iff (!rstN)
    crcPass |-> crcChecked);

  a_r6_silent_frames: assert property (@(posedge clk) disable iff (!rstN)
    crcChecked |-> !txValid);

  a_r7_overlength: assert property (@(posedge clk) disable iff (!rstN)
    overLen |-> (!crcChecked && !txValid));

endmodule

bind tagb_responder tagb_checker #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rstN(rstN), .txValid(txValid), .txReady(txReady),
  .txData(txData), .txLast(txLast), .cmdCount(cmdCount),
  .crcChecked(crcChecked), .crcPass(crcPass), .overLen(overLen)
);

// File: tb/sim_tagb_responder.sv
module sim_tagb_responder;

  localparam int CW   = 4;
  localparam int CMAX = (1 << CW) - 1;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic rxStart = 1'b0, rxEnd = 1'b0, rxValid = 1'b0, txReady = 1'b0;
  logic [7:0] rxData = 8'h00;
  logic txValid, txLast, crcChecked, crcPass, overLen;
  logic [7:0] txData;
  logic [CW-1:0] cmdCount;

  int nChecks = 0;
  int nFail = 0;
  int modelCnt = 0;
  bit finished = 0;
  logic [7:0] fb [0:79];

  always #2 clk = ~clk;

  tagb_responder #(.MAX_LEN(64), .CNT_W(CW)) u0 (
    .clk(clk), .rstN(rstN), .rxStart(rxStart), .rxEnd(rxEnd),
    .rxValid(rxValid), .rxData(rxData), .txValid(txValid),
    .txData(txData), .txLast(txLast), .txReady(txReady),
    .cmdCount(cmdCount), .crcChecked(crcChecked), .crcPass(crcPass),
    .overLen(overLen)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] crcOver(input int m);
    logic [15:0] c = 16'hFFFF;
    for (int i = 0; i < m; i++) begin
      c = c ^ {8'h00, fb[i]};
      for (int k = 0; k < 8; k++) c = c[0] ? ((c >> 1) ^ 16'h8408) : (c >> 1);
    end
    return c;
  endfunction

  task automatic setCrc(input int n);
    logic [15:0] c = ~crcOver(n - 2);
    fb[n-2] = c[7:0];
    fb[n-1] = c[15:8];
  endtask

  function automatic int expKind(input int n);
    if (n == 5 && fb[0] == 8'h05 && fb[1] == 8'h00 && fb[2] == 8'h08 &&
        fb[3] == 8'h39 && fb[4] == 8'h73) return 1;
    if (n == 5 && fb[0] == 8'h05 && fb[1] == 8'h00 && fb[2] == 8'h00 &&
        fb[3] == 8'h71 && fb[4] == 8'hFF) return 1;
    if (n == 5 && fb[0] == 8'h50) return 2;
    if (n == 11 && fb[0] == 8'h1D) return 2;
    return 0;
  endfunction

  function automatic logic [7:0] expReply(input int kind, input int j);
    logic [7:0] idr [0:13] = '{8'h50, 8'h82, 8'h0D, 8'hE1, 8'h74, 8'h20, 8'h38,
                               8'h19, 8'h22, 8'h00, 8'h21, 8'h85, 8'h5E, 8'hD7};
    logic [7:0] ack [0:2] = '{8'h00, 8'h78, 8'hF0};
    return (kind == 1) ? idr[j] : ack[j];
  endfunction

  task automatic runFrame(input int n, input bit sByte, input bit eByte,
                          input bit gaps, input bit noise, input string tag);
    int idx;
    int kind;
    int rlen;
    int j;
    int cyc;
    bit ended;
    bit expChk;
    bit expPass;
    kind = expKind(n);
    idx = 0;
    ended = 0;
    @(negedge clk);
    rxStart = 1'b1;
    rxEnd = 1'b0;
    if (n > 0 && sByte) begin
      rxValid = 1'b1;
      rxData = fb[0];
      idx = 1;
    end else begin
      rxValid = 1'b0;
    end
    while (idx < n) begin
      @(negedge clk);
      rxStart = 1'b0;
      if (gaps && (idx % 2 == 1)) begin
        rxValid = 1'b0;
        @(negedge clk);
      end
      rxValid = 1'b1;
      rxData = fb[idx];
      if (idx == n - 1 && eByte) begin
        rxEnd = 1'b1;
        ended = 1;
      end
      idx++;
    end
    if (!ended) begin
      @(negedge clk);
      rxStart = 1'b0;
      rxValid = 1'b0;
      rxEnd = 1'b1;
    end
    modelCnt = (modelCnt == CMAX) ? CMAX : modelCnt + 1;
    @(negedge clk);
    rxStart = 1'b0;
    rxValid = 1'b0;
    rxEnd = 1'b0;
    chk(txValid == 1'b0, "R9 no reply while judging", txValid, 0);
    @(negedge clk);
    expChk = (kind == 0) && n >= 3 && n <= 64;
    expPass = expChk && ({fb[n-1], fb[n-2]} == ~crcOver(n - 2));
    chk(cmdCount == CW'(modelCnt), "R8 count", cmdCount, modelCnt);
    chk(crcChecked == expChk, "R6 checked", crcChecked, expChk);
    chk(crcPass == expPass, "R6 pass", crcPass, expPass);
    chk(overLen == (n > 64), "R7 overlength", overLen, n > 64);
    chk(txValid == (kind != 0), tag, txValid, kind != 0);
    if (kind != 0 && txValid) begin
      rlen = (kind == 1) ? 14 : 3;
      j = 0;
      cyc = 0;
      while (j < rlen && cyc < 100) begin
        txReady = (cyc % 3) != 2;
        if (noise) begin
          rxStart = 1'b1;
          rxEnd = 1'b1;
          rxValid = 1'b1;
          rxData = 8'h05;
        end
        chk(txValid && txData == expReply(kind, j) && txLast == (j == rlen - 1),
            "R9 reply byte", {txValid, txLast, txData}, {1'b1, j == rlen - 1, expReply(kind, j)});
        @(negedge clk);
        if (txReady) j++;
        cyc++;
      end
      rxStart = 1'b0;
      rxEnd = 1'b0;
      rxValid = 1'b0;
      txReady = 1'b0;
      chk(txValid == 1'b0, "R9 reply ends", txValid, 0);
      chk(cmdCount == CW'(modelCnt), "R10 count after reply", cmdCount, modelCnt);
    end
  endtask

  task automatic loadProbe(input bit wake);
    fb[0] = 8'h05; fb[1] = 8'h00;
    fb[2] = wake ? 8'h08 : 8'h00;
    fb[3] = wake ? 8'h39 : 8'h71;
    fb[4] = wake ? 8'h73 : 8'hFF;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk(txValid == 0 && cmdCount == 0 && crcChecked == 0 && crcPass == 0 && overLen == 0,
        "R12 reset state", {txValid, cmdCount, crcChecked, crcPass, overLen}, 0);

    // R1 both strobe/byte orderings; wake-up frame carries a valid check value
    loadProbe(1);
    chk(crcOver(3) == ~{fb[4], fb[3]}, "R6 wake-up check value", crcOver(3), ~{fb[4], fb[3]});
    runFrame(5, 1, 1, 0, 0, "R1 wake-up reply");
    runFrame(5, 0, 0, 1, 0, "R1 wake-up reply split strobes");
    loadProbe(0);
    runFrame(5, 1, 0, 0, 0, "R2 request reply");

    for (int i = 0; i < 5; i++) fb[i] = 8'hFF;
    fb[0] = 8'h50;
    runFrame(5, 1, 1, 1, 0, "R3 halt reply");
    for (int i = 0; i < 11; i++) fb[i] = 8'(i * 37);
    fb[0] = 8'h1D;
    runFrame(11, 0, 1, 0, 0, "R4 attribute reply");

    // R10 strobes during reply
    loadProbe(1);
    runFrame(5, 1, 1, 0, 1, "R10 reply under noise");

    // R11 abandoned frame is not counted
    @(negedge clk);
    rxStart = 1'b1; rxValid = 1'b1; rxData = 8'h50;
    @(negedge clk);
    rxStart = 1'b0; rxData = 8'hFF;
    loadProbe(0);
    runFrame(5, 1, 1, 0, 0, "R11 restart then request");

    // R5/R6 sweep opcode byte over request frame body
    for (int b = 0; b < 256; b++) begin
      loadProbe(0);
      fb[0] = 8'(b);
      runFrame(5, b[0], b[1], b[2], 0, "R5 opcode sweep");
    end

    // R4/R5 length sweep with attribute opcode
    for (int n = 0; n <= 12; n++) begin
      for (int i = 0; i < 12; i++) fb[i] = 8'(i);
      fb[0] = 8'h1D;
      runFrame(n, 1, n[0], 0, 0, "R5 length sweep");
    end

    // R5/R6 every single-bit error in wake-up frame
    for (int p = 0; p < 5; p++) begin
      for (int k = 0; k < 8; k++) begin
        loadProbe(1);
        fb[p] = fb[p] ^ 8'(1 << k);
        runFrame(5, 1, 1, 0, 0, "R5 corrupted probe");
      end
    end

    // R6/R7 valid check values at several lengths, overlength boundary
    for (int t = 0; t < 5; t++) begin
      int n;
      n = (t == 0) ? 3 : (t == 1) ? 4 : (t == 2) ? 8 : (t == 3) ? 64 : 65;
      for (int i = 0; i < n; i++) fb[i] = 8'(i * 7 + 3);
      setCrc(n);
      runFrame(n, 1, 1, 0, 0, "R6 good check value");
      fb[1] = fb[1] ^ 8'h40;
      runFrame(n, 0, 0, 0, 0, "R7 bad check value");
    end

    chk(cmdCount == CW'(CMAX), "R8 saturated", cmdCount, CMAX);
    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", nChecks, nFail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      nChecks++;
      nFail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  [TB] %0d tests run, %0d failed", nChecks, nFail);
      $finish;
    end
  end

endmodule